// File: doc/BRIEF.md
# Byte-Strobed Write Target with Delayed Acknowledge

This block terminates the write half of a valid/ready memory-mapped bus. Three channels are involved: address, data and response. Each one moves a transfer only on a rising clock edge where its valid and ready are both high. The block takes one burst at a time. It accepts an address with its transaction ID, then accepts data beats into consecutive words of a small internal word store. Only the byte lanes whose strobe bit is set are written. The beat flagged as last closes the burst.

After the last beat, the block waits a parameterised number of clock cycles. This wait models the time the store needs to commit the data. The block then returns one response that carries the burst's ID and a 2-bit status. An address outside the window of the store gives a decode error and changes nothing. A burst that starts inside the window but runs past its last word gives a slave error. The beats that fall inside the window are still written. A combinational lookup port shows the content of any stored word to neighbouring logic.

Top module: `strb_wr_target`

## Requirements
- R1: After reset, aw_ready is 1, w_ready is 0, b_valid is 0, and every stored word reads 0 on the lookup port.
- R2: An address is taken on the edge where aw_valid and aw_ready are both 1. w_ready is 1 only while a burst is open. aw_ready stays 0 from that edge until the response handshake completes. Data beats offered while no address is open are not accepted and change nothing.
- R3: The strobe bus is DATA_W/8 bits wide. On an accepted beat, stored bits 8i+7..8i of the target word take w_data bits 8i+7..8i only when w_strb[i] is 1. Lanes whose strobe bit is 0 keep their old value.
- R4: Beat k of a burst goes to word index start+k. Here start = (aw_addr - BASE) >> log2(DATA_W/8), so the byte-offset bits of the address are ignored. The beat with w_last = 1 ends the burst.
- R5: Once b_valid is 1, it stays 1 with b_id and b_resp unchanged until the edge where b_ready is 1. On the next cycle b_valid is 0.
- R6: Exactly one response is given per burst. b_id equals the aw_id taken with its address. b_valid rises COMMIT_LAT+1 edges after the edge that accepts the last beat.
- R7: An aw_addr below BASE, or at or above BASE + DEPTH*DATA_W/8, ends in b_resp = 2'b11 (decode error), and no stored word changes.
- R8: A burst that starts in range but has beats past the last word ends in b_resp = 2'b10 (slave error). The out-of-range beats are dropped, and the in-range beats are still written.
- R9: Every other burst ends in b_resp = 2'b00 (OK).
- R10: peek_data shows stored word peek_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | output | 1 | Address channel ready |
| aw_addr | input | ADDR_W | Byte address of the first beat |
| aw_id | input | ID_W | Transaction ID |
| w_valid | input | 1 | Data channel valid |
| w_ready | output | 1 | Data channel ready |
| w_data | input | DATA_W | Beat data |
| w_strb | input | DATA_W/8 | Per-byte write enables |
| w_last | input | 1 | Marks the final beat |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | output | ID_W | ID of the completed burst |
| b_resp | output | 2 | Status: 00 OK, 10 slave error, 11 decode error |
| peek_idx | input | log2(DEPTH) | Word index for lookup |
| peek_data | output | DATA_W | Stored word at peek_idx |

## Verification
The bench counts edges relative to handshakes.

- **Address and data phases.** An address offered at a falling edge is taken on the next rising edge. From then on, w_ready is seen high at the next falling edge. Each beat lands in the store at its accepting edge, so the lookup port can be compared as soon as the burst is over.
- **Response latency.** After the last beat, the bench samples b_valid at every falling edge. It expects b_valid to be low for exactly COMMIT_LAT+1 samples, and to be high on the sample after those.
- **Response hold and release.** While b_ready is held low, the response fields are compared on several later falling edges. The falling edge after the ready handshake must show b_valid low and aw_ready high again.

// File: rtl/strb_wr_pkg.sv
`timescale 1ns/1ps
// Shared types for the strobed write target.
// Assumes: response codes are fixed 2-bit values decoded by the bus fabric.
package strb_wr_pkg;

    typedef enum logic [1:0] {
        RSP_OK     = 2'b00,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_DATA   = 2'b01,
        PH_COMMIT = 2'b10,
        PH_RESP   = 2'b11
    } phase_e;

endpackage

// File: rtl/strb_wr_decode.sv
`timescale 1ns/1ps
// Address window decoder.
// Maps a byte address to a word offset relative to BASE and flags whether the
// start word lies inside the store. Assumes BASE is word aligned.
module strb_wr_decode #(
    parameter int              ADDR_W = 12,
    parameter int              DATA_W = 32,
    parameter int              DEPTH  = 16,
    parameter logic [ADDR_W-1:0] BASE = 12'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] word_off
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LSB    = $clog2(BYTES);
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [ADDR_W-1:0] rel;

    // Compute the word offset and the in-window flag.
    always_comb begin
        rel      = addr - BASE;
        word_off = rel >> LSB;
        hit      = (addr >= BASE) && (word_off < DEPTH_A);
    end
endmodule

// File: rtl/strb_wr_store.sv
`timescale 1ns/1ps
// Byte-lane word store.
// One independent byte array per lane; a lane is written only when the write
// enable and its strobe bit are both set. Assumes idx is already range checked.
module strb_wr_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  strb,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);
    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        // Clear on reset, otherwise write this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= 8'h00;
            end else if (we && strb[l]) begin
                lane_mem[idx] <= wdata[l*8 +: 8];
            end
        end

        assign peek_data[l*8 +: 8] = lane_mem[peek_idx];
    end
endmodule

// File: rtl/strb_wr_ctrl.sv
`timescale 1ns/1ps
// Burst sequencer.
// Walks idle -> data -> commit wait -> response, tracks the beat offset and the
// error state, and drives the store write enable. Assumes one burst at a time.
module strb_wr_ctrl
    import strb_wr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ID_W       = 4,
    parameter int DEPTH      = 16,
    parameter int COMMIT_LAT = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic              dec_hit,
    input  logic [ADDR_W-1:0] dec_off,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx
);
    localparam int CNT_W = $clog2(COMMIT_LAT + 2);
    localparam int GAP_W = $clog2(COMMIT_LAT + 3);
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    phase_e            phase;
    logic [ID_W-1:0]   id_q;
    logic              dec_err_q;
    logic              slv_err_q;
    logic [ADDR_W-1:0] off_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              beat;
    logic              off_ok;

    assign aw_ready = (phase == PH_IDLE);
    assign w_ready  = (phase == PH_DATA);
    assign b_valid  = (phase == PH_RESP);
    assign b_id     = id_q;
    assign beat     = w_valid && w_ready;
    assign off_ok   = (off_q < DEPTH_A);
    assign st_we    = beat && !dec_err_q && off_ok;
    assign st_idx   = off_q[IDX_W-1:0];

    // Select the response code from the error state of the burst.
    always_comb begin
        if (dec_err_q)      b_resp = RSP_DECERR;
        else if (slv_err_q) b_resp = RSP_SLVERR;
        else                b_resp = RSP_OK;
    end

    // Phase sequencing, commit countdown and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            id_q      <= '0;
            dec_err_q <= 1'b0;
            slv_err_q <= 1'b0;
            off_q     <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (aw_valid) begin
                    id_q      <= aw_id;
                    dec_err_q <= !dec_hit;
                    slv_err_q <= 1'b0;
                    off_q     <= dec_off;
                    phase     <= PH_DATA;
                end
                PH_DATA: if (beat) begin
                    if (off_ok) off_q <= off_q + 1'b1;
                    else if (!dec_err_q) slv_err_q <= 1'b1;
                    if (w_last) begin
                        cnt_q <= CNT_W'(COMMIT_LAT);
                        phase <= PH_COMMIT;
                    end
                end
                PH_COMMIT: begin
                    if (cnt_q == '0) phase <= PH_RESP;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PH_RESP: if (b_ready) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Checker state: cycles spent waiting since the last beat was taken.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                      gap_q <= '0;
        else if (beat && w_last)         gap_q <= '0;
        else if (phase == PH_COMMIT)     gap_q <= gap_q + 1'b1;
    end

    assert_resp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id) && $stable(b_resp)));

    assert_single_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> !b_valid);

    assert_commit_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_valid) |-> (gap_q == GAP_W'(COMMIT_LAT + 1)));

    assert_aw_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ready || b_valid) |-> !aw_ready);

    assert_no_store_on_decerr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_resp == RSP_DECERR) |-> $past(!st_we));
endmodule

// File: rtl/strb_wr_target.sv
`timescale 1ns/1ps
// Strobed write target: top level.
// Ties the address decoder, burst sequencer and byte-lane store together.
// Assumes word-wide beats and incrementing word addresses within a burst.
module strb_wr_target #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                ID_W       = 4,
    parameter int                DEPTH      = 16,
    parameter int                COMMIT_LAT = 3,
    parameter logic [ADDR_W-1:0] BASE       = 12'h100,
    localparam int BYTES = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [ID_W-1:0]   aw_id,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [BYTES-1:0]  w_strb,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);
    logic              dec_hit;
    logic [ADDR_W-1:0] dec_off;
    logic              st_we;
    logic [IDX_W-1:0]  st_idx;

    strb_wr_decode #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .BASE (BASE)
    ) u_decode (
        .addr     (aw_addr),
        .hit      (dec_hit),
        .word_off (dec_off)
    );

    strb_wr_ctrl #(
        .ADDR_W (ADDR_W), .ID_W (ID_W), .DEPTH (DEPTH), .COMMIT_LAT (COMMIT_LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_valid (aw_valid),
        .aw_ready (aw_ready),
        .aw_id    (aw_id),
        .dec_hit  (dec_hit),
        .dec_off  (dec_off),
        .w_valid  (w_valid),
        .w_ready  (w_ready),
        .w_last   (w_last),
        .b_valid  (b_valid),
        .b_ready  (b_ready),
        .b_id     (b_id),
        .b_resp   (b_resp),
        .st_we    (st_we),
        .st_idx   (st_idx)
    );

    strb_wr_store #(
        .DATA_W (DATA_W), .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (st_we),
        .idx       (st_idx),
        .wdata     (w_data),
        .strb      (w_strb),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    assert_ready_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(aw_ready && w_ready));
endmodule

// File: tb/strb_wr_target_bench.sv
`timescale 1ns/1ps
module strb_wr_target_bench;
    localparam int LAT   = 3;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [11:0] aw_addr = '0;
    logic [3:0]  aw_id = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        b_valid;
    logic        b_ready = 1'b0;
    logic [3:0]  b_id;
    logic [1:0]  b_resp;
    logic [3:0]  peek_idx = '0;
    logic [31:0] peek_data;

    int total = 0;
    int bad = 0;
    logic [31:0] shadow [DEPTH];
    logic [31:0] bd [8];
    logic [3:0]  bs [8];

    always #2.5 clk = ~clk;

    strb_wr_target #(.COMMIT_LAT(LAT)) u_strb_wr_target (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
        .b_resp(b_resp), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every stored word against the shadow copy (R3, R4, R10).
    task automatic check_store(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            peek_idx = 4'(i);
            #0.5;
            chk(req, peek_data, shadow[i]);
        end
    endtask

    // Drive one burst of n beats from bd/bs and check the response path.
    task automatic run_burst(input logic [11:0] addr, input logic [3:0] id, input int n,
                             input string req);
        logic [1:0] exp_resp;
        int off;
        int lat;
        logic [3:0] hold_id;
        logic [1:0] hold_resp;
        // Expected outcome from the requirements (R7, R8, R9).
        if (addr < 12'h100 || addr >= 12'h140) exp_resp = 2'b11;
        else begin
            exp_resp = 2'b00;
            off = (int'(addr) - 'h100) >> 2;
            for (int k = 0; k < n; k++) begin
                if (off + k < DEPTH) begin
                    for (int l = 0; l < 4; l++)
                        if (bs[k][l]) shadow[off+k][l*8 +: 8] = bd[k][l*8 +: 8];
                end else exp_resp = 2'b10;
            end
        end
        @(negedge clk);
        aw_valid = 1'b1; aw_addr = addr; aw_id = id;
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        chk({req, " R2 aw_ready low in burst"}, 32'(aw_ready), 32'd0);
        for (int k = 0; k < n; k++) begin
            w_valid = 1'b1; w_data = bd[k]; w_strb = bs[k]; w_last = (k == n - 1);
            while (!w_ready) @(negedge clk);
            @(negedge clk);
        end
        w_valid = 1'b0; w_last = 1'b0;
        lat = 0;
        while (!b_valid && lat < 1000) begin
            lat++;
            chk({req, " R2 aw_ready low in commit"}, 32'(aw_ready), 32'd0);
            @(negedge clk);
        end
        chk({req, " R6 latency"}, 32'(lat), 32'(LAT + 1));
        chk({req, " R6 b_id"}, 32'(b_id), 32'(id));
        chk({req, " R7 R8 R9 b_resp"}, 32'(b_resp), 32'(exp_resp));
        hold_id = b_id; hold_resp = b_resp;
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            chk({req, " R5 hold valid"}, 32'(b_valid), 32'd1);
            chk({req, " R5 hold fields"}, {26'd0, b_resp, b_id}, {26'd0, hold_resp, hold_id});
        end
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        chk({req, " R6 one response"}, 32'(b_valid), 32'd0);
        chk({req, " R2 aw_ready back"}, 32'(aw_ready), 32'd1);
        check_store({req, " store"});
    endtask

    task automatic t_reset;
        chk("R1 aw_ready", 32'(aw_ready), 32'd1);
        chk("R1 w_ready", 32'(w_ready), 32'd0);
        chk("R1 b_valid", 32'(b_valid), 32'd0);
        check_store("R1 cleared");
    endtask

    task automatic t_full_word;
        bd[0] = 32'hDEADBEEF; bs[0] = 4'hF;
        run_burst(12'h100, 4'h1, 1, "R9 full word");
    endtask

    task automatic t_partial;
        bd[0] = 32'h11223344; bs[0] = 4'b0101;
        run_burst(12'h100, 4'h2, 1, "R3 partial lanes");
        bd[0] = 32'hAABBCCDD; bs[0] = 4'b1000;
        run_burst(12'h103, 4'h3, 1, "R4 offset bits ignored");
    endtask

    task automatic t_burst;
        bd[0] = 32'h01020304; bs[0] = 4'hF;
        bd[1] = 32'h55667788; bs[1] = 4'b0011;
        bd[2] = 32'h99AABBCC; bs[2] = 4'b1100;
        bd[3] = 32'hF0F0F0F0; bs[3] = 4'hF;
        run_burst(12'h114, 4'hA, 4, "R4 four beat burst");
        bd[0] = 32'h12345678; bs[0] = 4'b0110;
        bd[1] = 32'h87654321; bs[1] = 4'b1001;
        run_burst(12'h118, 4'hB, 2, "R3 overwrite lanes");
    endtask

    task automatic t_zero_strobe;
        bd[0] = 32'hFFFFFFFF; bs[0] = 4'h0;
        run_burst(12'h100, 4'h4, 1, "R3 zero strobe");
    endtask

    task automatic t_decode_err;
        bd[0] = 32'hCAFEF00D; bs[0] = 4'hF;
        bd[1] = 32'hCAFEF00D; bs[1] = 4'hF;
        run_burst(12'h0FC, 4'h5, 2, "R7 below window");
        run_burst(12'h140, 4'h6, 1, "R7 above window");
    endtask

    task automatic t_slave_err;
        bd[0] = 32'hA1A1A1A1; bs[0] = 4'hF;
        bd[1] = 32'hB2B2B2B2; bs[1] = 4'hF;
        bd[2] = 32'hC3C3C3C3; bs[2] = 4'hF;
        bd[3] = 32'hD4D4D4D4; bs[3] = 4'hF;
        run_burst(12'h138, 4'h7, 4, "R8 runs past end");
        bd[0] = 32'h0BADCAFE; bs[0] = 4'hF;
        run_burst(12'h13C, 4'h8, 1, "R9 last word");
    endtask

    task automatic t_orphan_data;
        @(negedge clk);
        w_valid = 1'b1; w_data = 32'h77777777; w_strb = 4'hF; w_last = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R2 no data without address", 32'(w_ready), 32'd0);
            chk("R2 no response without address", 32'(b_valid), 32'd0);
        end
        w_valid = 1'b0; w_last = 1'b0;
        check_store("R2 orphan data ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_partial();
        t_burst();
        t_zero_strobe();
        t_decode_err();
        t_slave_err();
        t_orphan_data();
        t_full_word();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule